// File: doc/BRIEF.md
# Branch-in-Decode Hazard Unit

This block is the hazard detection and forwarding-control logic for a five-stage, in-order integer pipeline. Conditional branches and all jumps resolve in the decode stage, so the branch comparator and the jump-register target read their operands early. The unit is purely combinational. Each cycle it looks at what decode needs and what the execute, memory and writeback stages will write. From that it decides whether decode must wait, whether the instruction fetched behind a control transfer must be squashed, and where each operand should come from.

Fetch is statically predicted not taken. When a transfer resolves as taken, the one instruction already fetched behind it is flushed. A stall holds the program counter and the fetch/decode register and inserts a bubble into execute. A stall always wins over a flush, so the branch is evaluated again once its operands are ready. An all-zero instruction word is an ordinary no-operation: it decodes as a plain ALU-class instruction with register 0 as its sources.

Top module: `bdhz_unit`

## Requirements
- R1: If decode holds a conditional branch (class 1) or a jump-register (class 2), and a used source matches a non-load producer in execute, then `stall_fd` and `bubble_ex` are both 1; these two outputs are always equal.
- R2: A load in execute whose destination feeds a used source of a class 1 or class 2 instruction in decode causes a stall; together with R3 this gives two stall cycles when a load directly precedes such a branch.
- R3: A load in the memory stage whose destination feeds a used source of a class 1 or class 2 instruction in decode causes a stall.
- R4: For a decode instruction of class 0 (ordinary), only a load in execute that feeds a used source causes a stall; an ALU producer in execute or a load in memory does not.
- R5: `flush_fd` is 1 for class 3 (direct jump or jump-and-link) and class 2, and for class 1 only when `id_taken` is 1; it is 0 for class 0 and for a branch that is not taken.
- R6: Whenever `stall_fd` is 1, `flush_fd` is 0.
- R7: Each decode forwarding select reads 1 when a non-load in memory writes that source, otherwise 2 when writeback writes it, otherwise 0 (register file); memory wins over writeback.
- R8: Each execute forwarding select uses the same codes (1 memory, 2 writeback, 0 register file), with memory winning over writeback.
- R9: Register 0 never causes a stall or a forward, and a source marked unused never causes a stall.
- R10: An all-zero instruction in decode (class 0, sources 0) with idle downstream stages gives no stall, no flush and all selects 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_cls | input | 2 | Decode class: 0 ordinary, 1 conditional branch, 2 jump-register, 3 direct jump |
| id_rs | input | REG_W | Decode first source register |
| id_rt | input | REG_W | Decode second source register |
| id_rs_used | input | 1 | First source is read |
| id_rt_used | input | 1 | Second source is read |
| id_taken | input | 1 | Decode comparator outcome for class 1 |
| ex_rd | input | REG_W | Execute destination register |
| ex_we | input | 1 | Execute writes a register |
| ex_load | input | 1 | Execute holds a load |
| ex_rs | input | REG_W | Execute first ALU source |
| ex_rt | input | REG_W | Execute second ALU source |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_we | input | 1 | Memory stage writes a register |
| mem_load | input | 1 | Memory stage holds a load |
| wb_rd | input | REG_W | Writeback destination register |
| wb_we | input | 1 | Writeback writes a register |
| stall_fd | output | 1 | Hold PC and fetch/decode register |
| bubble_ex | output | 1 | Insert a bubble into execute |
| flush_fd | output | 1 | Squash the instruction behind a taken transfer |
| id_fwd_a | output | 2 | Decode first-operand source select |
| id_fwd_b | output | 2 | Decode second-operand source select |
| ex_fwd_a | output | 2 | Execute first-operand source select |
| ex_fwd_b | output | 2 | Execute second-operand source select |

## Verification
Several rules hold for every input combination, and the embedded checks watch them on each evaluation. A stall never coincides with a flush, a flush only comes from a control class, and nothing ever forwards register 0. Every ordinary-class stall must trace back to a load in execute, and writeback is only chosen when memory does not also match. The exact stall counts for a load right before a branch (two) and for an ALU producer right before a branch (one) depend on the pipeline advancing across cycles. So do the hand-off to forwarding that follows those stalls. Only the bench's stepped sequences show these.

// File: rtl/bdhz_unit.sv
module bdhz_unit #(
  parameter int REG_W = 5
) (
  input  logic [1:0]       id_cls,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rs_used,
  input  logic             id_rt_used,
  input  logic             id_taken,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic             stall_fd,
  output logic             bubble_ex,
  output logic             flush_fd,
  output logic [1:0]       id_fwd_a,
  output logic [1:0]       id_fwd_b,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b
);
  localparam logic [1:0] CLS_ALU = 2'd0;
  localparam logic [1:0] CLS_BR  = 2'd1;
  localparam logic [1:0] CLS_JR  = 2'd2;
  localparam logic [1:0] CLS_JMP = 2'd3;
  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;

  function automatic logic dep(input logic [REG_W-1:0] src, input logic used,
                               input logic [REG_W-1:0] dst, input logic we);
    return used && we && (src != '0) && (src == dst);
  endfunction

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src,
                                      input logic [REG_W-1:0] mrd, input logic mwe,
                                      input logic [REG_W-1:0] wrd, input logic wwe);
    if (dep(src, 1'b1, mrd, mwe))      return SEL_MEM;
    else if (dep(src, 1'b1, wrd, wwe)) return SEL_WB;
    else                               return SEL_RF;
  endfunction

  logic early, ex_dep, memld_dep, xfer, hold;

  assign early     = (id_cls == CLS_BR) || (id_cls == CLS_JR);
  assign ex_dep    = dep(id_rs, id_rs_used, ex_rd, ex_we) || dep(id_rt, id_rt_used, ex_rd, ex_we);
  assign memld_dep = dep(id_rs, id_rs_used, mem_rd, mem_we && mem_load) ||
                     dep(id_rt, id_rt_used, mem_rd, mem_we && mem_load);
  assign hold      = early ? (ex_dep || memld_dep) : (ex_dep && ex_load);
  assign xfer      = (id_cls == CLS_JMP) || (id_cls == CLS_JR) || ((id_cls == CLS_BR) && id_taken);

  assign stall_fd  = hold;
  assign bubble_ex = hold;
  assign flush_fd  = xfer && !hold;

  assign id_fwd_a = pick(id_rs, mem_rd, mem_we && !mem_load, wb_rd, wb_we);
  assign id_fwd_b = pick(id_rt, mem_rd, mem_we && !mem_load, wb_rd, wb_we);
  assign ex_fwd_a = pick(ex_rs, mem_rd, mem_we, wb_rd, wb_we);
  assign ex_fwd_b = pick(ex_rt, mem_rd, mem_we, wb_rd, wb_we);

  always_comb begin
    // R6
    no_flush_in_stall_chk: assert (!(stall_fd && flush_fd)) else $error("flush during stall");
    // R5
    flush_only_control_chk: assert (!(flush_fd && id_cls == CLS_ALU)) else $error("flush on ordinary class");
    // R4
    ordinary_stall_load_chk: assert (!(stall_fd && id_cls == CLS_ALU) || (ex_load && ex_we)) else $error("ordinary stall without load");
    // R9
    zero_never_fwd_chk: assert ((id_fwd_a == SEL_RF || id_rs != '0) && (id_fwd_b == SEL_RF || id_rt != '0) &&
                                (ex_fwd_a == SEL_RF || ex_rs != '0) && (ex_fwd_b == SEL_RF || ex_rt != '0))
      else $error("register zero forwarded");
    // R8
    mem_over_wb_chk: assert (!(ex_fwd_a == SEL_WB && mem_we && mem_rd == ex_rs) &&
                             !(ex_fwd_b == SEL_WB && mem_we && mem_rd == ex_rt))
      else $error("writeback chosen over memory");
    // R1
    stall_bubble_pair_chk: assert (stall_fd == bubble_ex) else $error("stall and bubble differ");
  end
endmodule

// File: tb/bdhz_unit_test.sv
module bdhz_unit_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [3:0] rq;
    logic [1:0] cls;
    logic [4:0] rs, rt;
    logic urs, urt, tk;
    logic [4:0] erd; logic ewe, eld;
    logic [4:0] mrd; logic mwe, mld;
    logic [4:0] wrd; logic wwe;
    logic [4:0] xrs, xrt;
    logic st, fl;
    logic [1:0] da, db, xa, xb;
  } vec_t;

  localparam int NV = 19;
  // fields: rq cls rs rt urs urt tk | erd ewe eld | mrd mwe mld | wrd wwe | xrs xrt | st fl da db xa xb
  localparam vec_t VEC [NV] = '{
    '{4'd10, 2'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R10
    '{4'd1,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b1, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R1
    '{4'd2,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R2
    '{4'd3,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R3
    '{4'd7,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 2'd0}, // R7
    '{4'd7,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0, 2'd0}, // R7
    '{4'd7,  2'd1, 5'd8, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, 5'd8, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, 2'd0}, // R7
    '{4'd5,  2'd3, 5'd8, 5'd0, 1'b0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0}, // R5
    '{4'd6,  2'd2, 5'd31,5'd0, 1'b1, 1'b0, 1'b0, 5'd31,1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R6
    '{4'd5,  2'd2, 5'd31,5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0}, // R5
    '{4'd5,  2'd1, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R5
    '{4'd4,  2'd0, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R4
    '{4'd4,  2'd0, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R4
    '{4'd4,  2'd0, 5'd8, 5'd9, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R4
    '{4'd9,  2'd1, 5'd0, 5'd0, 1'b1, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0}, // R9
    '{4'd8,  2'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd10,1'b1, 1'b0, 5'd11,1'b1, 5'd10,5'd11,1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd2}, // R8
    '{4'd8,  2'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd10,1'b1, 1'b0, 5'd10,1'b1, 5'd10,5'd10,1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd1}, // R8
    '{4'd9,  2'd1, 5'd8, 5'd9, 1'b0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}, // R9
    '{4'd9,  2'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0}  // R9
  };

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [1:0] id_cls; logic [4:0] id_rs, id_rt; logic id_rs_used, id_rt_used, id_taken;
  logic [4:0] ex_rd, ex_rs, ex_rt, mem_rd, wb_rd; logic ex_we, ex_load, mem_we, mem_load, wb_we;
  logic stall_fd, bubble_ex, flush_fd; logic [1:0] id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b;

  bdhz_unit #(.REG_W(5)) uut (
    .id_cls(id_cls), .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_used(id_rt_used),
    .id_taken(id_taken), .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .wb_rd(wb_rd), .wb_we(wb_we),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex), .flush_fd(flush_fd),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b));

  int runs = 0, fails = 0, stalls = 0;
  bit done = 0;

  task automatic drive(input vec_t v);
    @(posedge clk);
    id_cls = v.cls; id_rs = v.rs; id_rt = v.rt; id_rs_used = v.urs; id_rt_used = v.urt; id_taken = v.tk;
    ex_rd = v.erd; ex_we = v.ewe; ex_load = v.eld; mem_rd = v.mrd; mem_we = v.mwe; mem_load = v.mld;
    wb_rd = v.wrd; wb_we = v.wwe; ex_rs = v.xrs; ex_rt = v.xrt;
    @(negedge clk);
  endtask

  task automatic check(input vec_t v, input string tag);
    logic [11:0] got, exp;
    got = {stall_fd, bubble_ex, flush_fd, 1'b0, id_fwd_a, id_fwd_b, ex_fwd_a, ex_fwd_b};
    exp = {v.st, v.st, v.fl, 1'b0, v.da, v.db, v.xa, v.xb};
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", v.rq, tag, got, exp);
    end
  endtask

  function automatic vec_t blank(input logic [3:0] rq);
    vec_t v = '0;
    v.rq = rq;
    return v;
  endfunction

  initial begin
    vec_t v;
    // R10 idle state
    v = blank(4'd10);
    drive(v); check(v, "idle");
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]); check(VEC[i], "vector");
    end

    // R2 and R3: load directly before a dependent taken branch, pipeline advancing
    v = blank(4'd2); v.cls = 2'd1; v.rs = 5'd8; v.rt = 5'd13; v.urs = 1; v.urt = 1; v.tk = 1;
    v.erd = 5'd13; v.ewe = 1; v.eld = 1; v.st = 1;
    drive(v); check(v, "load in execute"); stalls = stalls + int'(stall_fd);
    v.rq = 4'd3; v.erd = 5'd0; v.ewe = 0; v.eld = 0; v.mrd = 5'd13; v.mwe = 1; v.mld = 1;
    drive(v); check(v, "load in memory"); stalls = stalls + int'(stall_fd);
    v.rq = 4'd7; v.mrd = 5'd0; v.mwe = 0; v.mld = 0; v.wrd = 5'd13; v.wwe = 1; v.st = 0; v.fl = 1; v.db = 2'd2;
    drive(v); check(v, "load in writeback"); stalls = stalls + int'(stall_fd);
    runs++;
    if (stalls != 2) begin fails++; $display("FAIL R2 total stalls got %0d expected 2", stalls); end

    // R1: ALU producer right before branch, one stall then memory forward
    stalls = 0;
    v = blank(4'd1); v.cls = 2'd1; v.rs = 5'd9; v.rt = 5'd4; v.urs = 1; v.urt = 1; v.tk = 1;
    v.erd = 5'd9; v.ewe = 1; v.st = 1;
    drive(v); check(v, "alu in execute"); stalls = stalls + int'(stall_fd);
    v.rq = 4'd7; v.erd = 5'd0; v.ewe = 0; v.mrd = 5'd9; v.mwe = 1; v.st = 0; v.fl = 1; v.da = 2'd1;
    drive(v); check(v, "alu in memory"); stalls = stalls + int'(stall_fd);
    runs++;
    if (stalls != 1) begin fails++; $display("FAIL R1 total stalls got %0d expected 1", stalls); end

    // R4: load-use for ordinary consumer then writeback forward in execute
    v = blank(4'd4); v.rs = 5'd6; v.urs = 1; v.erd = 5'd6; v.ewe = 1; v.eld = 1; v.st = 1;
    drive(v); check(v, "load use");
    v = blank(4'd8); v.xrs = 5'd6; v.wrd = 5'd6; v.wwe = 1; v.xa = 2'd2;
    drive(v); check(v, "load data from writeback");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++; runs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule